// File: doc/BRIEF.md
# Autovectored Interrupt Vector Substitution

This block gathers fourteen interrupt sources from FIFO status and a transfer engine into a single interrupt request line for a small 8-bit CPU. Each source has a sticky request flag and an enable bit. The block ranks the enabled pending sources by a fixed priority and forms an 8-bit vector byte for the winner.

When the CPU takes the interrupt, it fetches a jump instruction at code address 0x0053. The high byte of the jump target comes from ordinary memory at 0x0054. The low byte is fetched from 0x0055. While autovectoring is enabled, the block replaces the memory data of that low-byte fetch with the vector byte, so the jump lands on the handler slot for the chosen source.

A two-state tracker freezes the vector when the jump opcode is fetched. A request that arrives late therefore cannot change a jump that is already under way. The states are TRACK and HELD:

- TRACK is the reset state. In TRACK the vector register copies the arbitration result on every clock.
- TRACK goes to HELD on a strobed fetch of 0x0053. The vector is captured on that same clock.
- HELD stays in HELD on a repeated strobed fetch of 0x0053, which captures the vector again. Any other HELD cycle without a strobed fetch of 0x0055 keeps the vector unchanged.
- HELD goes to TRACK on a strobed fetch of 0x0055.

Top module: `avec_subst`

## Requirements
- R1: A one-cycle pulse on `evt_set[i]` sets request flag i at the next clock edge. The flag then stays set with no further pulse.
- R2: A pulse on `evt_clr[i]` clears flag i at the next clock edge. If set and clear arrive for the same bit in the same cycle, the flag is set.
- R3: A source takes part in arbitration only when both its flag and `src_en[i]` are 1. `irq` is 1 exactly when at least one such source exists.
- R4: Priority follows bit index, and the lowest index wins. Bits 0 to 3 are the programmable-level flags of endpoints 2, 4, 6 and 8. Bits 4 to 7 are the empty flags of the same endpoints. Bits 8 to 11 are the full flags of the same endpoints. Bit 12 is transfer-done and bit 13 is waveform.
- R5: The vector byte for winning bit i is 0x80 + 4*i, which runs from 0x80 for bit 0 to 0xB4 for bit 13.
- R6: With no enabled pending source, the vector byte is 0x80 and `irq` is 0.
- R7: A strobed fetch of 0x0053 captures the current vector. The captured value is held, unaffected by new requests, until a strobed fetch of 0x0055 is done.
- R8: When `av_en` is 1, a strobed fetch of 0x0055 returns the held vector byte on `cpu_data` in the same cycle.
- R9: `cpu_data` equals `mem_data` in three cases: when `av_en` is 0, when `fetch_stb` is 0, or when the fetch address is anything other than 0x0055.
- R10: After reset the vector register is 0x80, the tracker is in TRACK and all flags are 0. In TRACK the vector register follows the arbitration result one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 14 | Per-source event pulses that set flags |
| evt_clr | input | 14 | Per-source write-one-to-clear strobes |
| src_en | input | 14 | Per-source enable bits |
| av_en | input | 1 | Autovector substitution enable |
| fetch_addr | input | 16 | Code fetch address |
| fetch_stb | input | 1 | Code fetch strobe |
| mem_data | input | 8 | Data from code memory |
| cpu_data | output | 8 | Data returned to the CPU |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that event and clear inputs, fetch address and strobe change only between clock edges, and that a fetch is valid only in the cycle its strobe is high. The bench drives every input on the falling edge and samples a couple of nanoseconds later. A fetch occupies one strobed cycle and is followed by an idle cycle, so a jump fetch is never accidentally repeated while a late request is injected.

// File: rtl/avec_pkg.sv
package avec_pkg;
    typedef enum logic [0:0] {
        ST_TRACK = 1'b0,
        ST_HELD  = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/avec_flag_bank.sv
module avec_flag_bank #(
    parameter int NSRC = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_set,
    input  logic [NSRC-1:0] evt_clr,
    output logic [NSRC-1:0] flags
);
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_flag
            logic flag_q;
            always_ff @(posedge clk) begin
                if (!rst_n)          flag_q <= 1'b0;
                else if (evt_set[g]) flag_q <= 1'b1;
                else if (evt_clr[g]) flag_q <= 1'b0;
            end
            assign flags[g] = flag_q;

            // R1 R2
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt_set[g] |=> flags[g]);
            // R2
            clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_clr[g] && !evt_set[g]) |=> !flags[g]);
            // R1
            sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[g] && !evt_clr[g]) |=> flags[g]);
        end
    endgenerate
endmodule

// File: rtl/avec_prio_enc.sv
module avec_prio_enc #(
    parameter int          NSRC     = 14,
    parameter int          DW       = 8,
    parameter logic [7:0]  VEC_BASE = 8'h80,
    parameter int          STRIDE_SH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] grant,
    output logic            any,
    output logic [DW-1:0]   vec
);
    localparam int IW = $clog2(NSRC);

    logic [IW-1:0] idx;

    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
        any   = |pend;
        grant = '0;
        if (any) grant[idx] = 1'b1;
        vec = DW'(VEC_BASE) + (DW'(idx) << STRIDE_SH);
    end

    // R3 R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~pend) == '0));
    // R3
    irq_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any == (grant != '0));
    // R6
    idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (vec == DW'(VEC_BASE)));
endmodule

// File: rtl/avec_fetch_fsm.sv
module avec_fetch_fsm
    import avec_pkg::*;
#(
    parameter int           AW        = 16,
    parameter int           DW        = 8,
    parameter logic [15:0]  JMP_ADDR  = 16'h0053,
    parameter logic [15:0]  LOW_ADDR  = 16'h0055,
    parameter logic [7:0]   VEC_BASE  = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] fetch_addr,
    input  logic          fetch_stb,
    input  logic [DW-1:0] live_vec,
    output logic [DW-1:0] vec_q
);
    fetch_state_e state_q, state_d;
    logic jmp_fetch, low_fetch;

    assign jmp_fetch = fetch_stb && (fetch_addr == AW'(JMP_ADDR));
    assign low_fetch = fetch_stb && (fetch_addr == AW'(LOW_ADDR));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: if (jmp_fetch) state_d = ST_HELD;
            ST_HELD: begin
                if (jmp_fetch)      state_d = ST_HELD;
                else if (low_fetch) state_d = ST_TRACK;
            end
            default: state_d = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             vec_q <= DW'(VEC_BASE);
        else if (state_q == ST_TRACK || jmp_fetch) vec_q <= live_vec;
    end

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !jmp_fetch) |=> $stable(vec_q));
    // R7
    jmp_enters_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_fetch |=> (state_q == ST_HELD));
    // R7
    low_exits_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && low_fetch && !jmp_fetch) |=> (state_q == ST_TRACK));
endmodule

// File: rtl/avec_subst.sv
module avec_subst #(
    parameter int          NSRC      = 14,
    parameter int          AW        = 16,
    parameter int          DW        = 8,
    parameter logic [15:0] JMP_ADDR  = 16'h0053,
    parameter logic [15:0] LOW_ADDR  = 16'h0055,
    parameter logic [7:0]  VEC_BASE  = 8'h80,
    parameter int          STRIDE_SH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_set,
    input  logic [NSRC-1:0] evt_clr,
    input  logic [NSRC-1:0] src_en,
    input  logic            av_en,
    input  logic [AW-1:0]   fetch_addr,
    input  logic            fetch_stb,
    input  logic [DW-1:0]   mem_data,
    output logic [DW-1:0]   cpu_data,
    output logic            irq
);
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] grant;
    logic [DW-1:0]   live_vec;
    logic [DW-1:0]   vec_q;
    logic            substitute;

    avec_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr), .flags(flags)
    );

    assign pend = flags & src_en;

    avec_prio_enc #(
        .NSRC(NSRC), .DW(DW), .VEC_BASE(VEC_BASE), .STRIDE_SH(STRIDE_SH)
    ) u_prio (
        .clk(clk), .rst_n(rst_n), .pend(pend), .grant(grant), .any(irq), .vec(live_vec)
    );

    avec_fetch_fsm #(
        .AW(AW), .DW(DW), .JMP_ADDR(JMP_ADDR), .LOW_ADDR(LOW_ADDR), .VEC_BASE(VEC_BASE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_stb(fetch_stb),
        .live_vec(live_vec), .vec_q(vec_q)
    );

    assign substitute = av_en && fetch_stb && (fetch_addr == AW'(LOW_ADDR));
    assign cpu_data   = substitute ? vec_q : mem_data;

    // R9
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!av_en || !fetch_stb) |-> (cpu_data == mem_data));
    // R8
    subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        substitute |-> (cpu_data == vec_q));
endmodule

// File: tb/avec_subst_tb.sv
module avec_subst_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] evt_set, evt_clr, src_en;
    logic        av_en;
    logic [15:0] fetch_addr;
    logic        fetch_stb;
    logic [7:0]  mem_data;
    logic [7:0]  cpu_data;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    avec_subst u_dut (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr), .src_en(src_en),
        .av_en(av_en), .fetch_addr(fetch_addr), .fetch_stb(fetch_stb),
        .mem_data(mem_data), .cpu_data(cpu_data), .irq(irq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse(logic [13:0] s, logic [13:0] c);
        @(negedge clk); evt_set = s; evt_clr = c;
        @(negedge clk); evt_set = '0; evt_clr = '0;
    endtask

    task automatic fetch(logic [15:0] a, output logic [7:0] d);
        @(negedge clk); fetch_addr = a; fetch_stb = 1'b1;
        #2 d = cpu_data;
        @(negedge clk); fetch_stb = 1'b0; fetch_addr = 16'h0000;
    endtask

    task automatic take_irq(output logic [7:0] d);
        logic [7:0] tmp;
        fetch(16'h0053, tmp);
        fetch(16'h0055, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        #2 chk("R10 irq after reset", {7'b0, irq}, 8'h00);
        fetch(16'h0055, d);
        chk("R10 R6 vector after reset", d, 8'h80);
        @(negedge clk); #2 chk("R9 idle passthrough", cpu_data, mem_data);
    endtask

    task automatic t_each_rank();
        logic [7:0] d;
        for (int k = 0; k < 14; k++) begin
            pulse(14'(1) << k, '0);
            take_irq(d);
            chk("R5 R1 rank vector", d, 8'h80 + 8'(k * 4));
            pulse('0, 14'(1) << k);
        end
    endtask

    task automatic t_priority();
        logic [7:0] d;
        pulse(14'b10_0101_0000_0000, '0); // bits 13, 10, 8
        take_irq(d);
        chk("R4 full flag beats waveform", d, 8'hA0);
        pulse(14'b00_0000_0010_0000, '0); // bit 5
        take_irq(d);
        chk("R4 empty flag beats full", d, 8'h94);
        pulse('0, '1);
        @(negedge clk); #2 chk("R2 clear all irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        src_en = 14'h3FFE;
        pulse(14'h0001, '0);
        #2 chk("R3 masked no irq", {7'b0, irq}, 8'h00);
        take_irq(d);
        chk("R3 R6 masked vector", d, 8'h80);
        pulse(14'h0008, '0);
        take_irq(d);
        chk("R3 masked skipped", d, 8'h8C);
        src_en = '1;
        pulse('0, '1);
    endtask

    task automatic t_av_off();
        logic [7:0] d;
        pulse(14'h0004, '0);
        av_en = 1'b0;
        take_irq(d);
        chk("R9 av disabled passthrough", d, mem_data);
        av_en = 1'b1;
        fetch(16'h0054, d);
        chk("R9 other address passthrough", d, mem_data);
        pulse('0, '1);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        pulse(14'h0400, '0); // bit 10
        fetch(16'h0053, d);
        pulse(14'h0001, '0); // higher priority arrives late
        fetch(16'h0055, d);
        chk("R7 late request ignored", d, 8'hA8);
        take_irq(d);
        chk("R7 next jump sees new winner", d, 8'h80);
        pulse('0, '1);
    endtask

    task automatic t_setclr();
        pulse(14'h0200, '0);
        pulse(14'h0200, 14'h0200);
        #2 chk("R2 set wins over clear", {7'b0, irq}, 8'h01);
        pulse('0, 14'h0200);
        #2 chk("R2 clear drops irq", {7'b0, irq}, 8'h00);
        repeat (3) @(negedge clk);
        pulse(14'h0002, '0);
        repeat (4) @(negedge clk);
        #2 chk("R1 flag sticks", {7'b0, irq}, 8'h01);
        pulse('0, '1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt_set = '0; evt_clr = '0; src_en = '1; av_en = 1'b1;
        fetch_addr = '0; fetch_stb = 1'b0; mem_data = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_each_rank();
        t_priority();
        t_mask();
        t_av_off();
        t_latch();
        t_setclr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule